// File: doc/BRIEF.md
# Floating-Point Exception Status Unit

This unit keeps the 16-bit status word of a stack-based floating-point unit. Arithmetic units send it exception requests: a set of flag bits, an optional stack-fault marker and a C1 qualifier. The unit compares each request with the mask bits in the current control word. It sets sticky exception flags, the stack-fault bit and the C1 condition bit. It keeps the error-summary and busy bits equal to "some raised flag is unmasked". It also reports, one cycle after a request, whether the core must take a floating-point trap.

An internal-fault strobe marks a broken datapath. It sets every exception flag and both summary bits at once, and it always reports a trap. A synchronous clear command wipes the exception state and leaves the condition codes and the stack-top field alone. The stack-top field can be loaded directly. All other condition bits reset to zero and are not changed by this unit. Any status change shows on `status_word` after the clock edge that samples the request.

Top module: `fpu_exc_status`

## Requirements
- R1: After reset, `status_word` is 0x0000 and `unmasked_exc` is 0.
- R2: A request (`req_valid`=1) ORs `req_flags` into the status flags: invalid=bit 0, denormal=bit 1, zero-divide=bit 2, overflow=bit 3, underflow=bit 4, precision=bit 5. Flags stay set until a clear.
- R3: After a request, error summary (bit 7) and busy (bit 15) are both 1 if and only if some set flag in bits 5:0 has its mask bit clear in `ctrl_word[5:0]`. Otherwise both are 0. The two bits are always equal.
- R4: `int_fault` sets bits 5:0, bit 7 and bit 15 whatever the masks are, and raises `unmasked_exc` one cycle later. It takes priority over a request in the same cycle, which is then ignored.
- R5: A request that carries the stack-fault marker or the precision flag writes `req_c1` into C1 (bit 9). Any other request leaves C1 unchanged.
- R6: `req_stack_fault` sets the stack-fault bit (bit 6), and the bit stays set until a clear.
- R7: `unmasked_exc` is high for the cycle after a request exactly when some requested flag has its mask bit clear, or when an internal fault occurred. Otherwise it is low. A masked denormal request only sets bit 1.
- R8: `clear` zeroes bits 7:0 and bit 15, and forces `unmasked_exc` low. It leaves C0 (bit 8), C1 (bit 9), C2 (bit 10), C3 (bit 14) and the stack-top field unchanged. It takes priority over a request or an internal fault in the same cycle.
- R9: `top_load` writes `top_value` into bits 13:11 and changes no other bit. This also applies in a cycle that clears.
- R10: `ctrl_word[15:6]` has no effect on the status word or on `unmasked_exc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Exception request strobe |
| req_flags | input | 6 | Exception flags of the request |
| req_stack_fault | input | 1 | Request is a stack fault |
| req_c1 | input | 1 | C1 qualifier (stack overflow / rounded up) |
| int_fault | input | 1 | Internal datapath fault strobe |
| ctrl_word | input | 16 | Control word, mask bits in 5:0 |
| clear | input | 1 | Clear exception state |
| top_load | input | 1 | Load the stack-top field |
| top_value | input | 3 | New stack-top value |
| status_word | output | 16 | Status word |
| unmasked_exc | output | 1 | Registered unmasked-exception indication |

## Verification
The hardest case is the summary bits falling back to zero. This happens when a flag raised earlier while unmasked becomes masked before the next request arrives. The summary must then be recomputed from the whole flag set, not from the new request alone. The stimulus reaches this case in three steps. It raises invalid with its mask clear, then sets every mask, then sends a masked overflow request. The expected result is that the invalid flag stays set while bits 7 and 15 drop. Same-cycle collisions of clear, internal fault, request and stack-top load are driven on purpose to confirm the priority order.

// File: rtl/fpu_exc_pkg.sv
// Shared constants and types for the floating-point exception status unit.
// Assumes the fixed 16-bit status word layout given in the brief.
package fpu_exc_pkg;
    localparam int SW_W     = 16;
    localparam int NFLAG    = 6;
    localparam int TOP_W    = 3;

    localparam int B_PE     = 5;
    localparam int B_SF     = 6;
    localparam int B_ES     = 7;
    localparam int B_C1     = 9;
    localparam int B_TOP_LO = 11;
    localparam int B_TOP_HI = B_TOP_LO + TOP_W - 1;
    localparam int B_BUSY   = 15;

    typedef logic [NFLAG-1:0] flag_t;

    typedef struct packed {
        logic  valid;
        flag_t flags;
        logic  stk;
        logic  c1q;
    } exc_req_t;

    // True when any flag in f has its mask bit clear
    function automatic logic any_open(input flag_t f, input flag_t m);
        return |(f & ~m);
    endfunction
endpackage

// File: rtl/fpu_exc_update.sv
// Next-state logic for the status word.
// Priority: clear, then internal fault, then a normal request.
// A stack-top load is applied on top of any of these.
// Assumes the caller registers the result.
module fpu_exc_update
    import fpu_exc_pkg::*;
(
    input  logic [SW_W-1:0]  cur_sw,
    input  exc_req_t         req,
    input  logic             ifault,
    input  logic             clr,
    input  flag_t            mask,
    input  logic             top_ld,
    input  logic [TOP_W-1:0] top_val,
    output logic [SW_W-1:0]  nxt_sw
);
    flag_t flag_nxt;

    // One sticky flag per exception type
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        assign flag_nxt[i] = clr    ? 1'b0 :
                             ifault ? 1'b1 :
                             (cur_sw[i] | (req.valid & req.flags[i]));
    end

    // Assemble the next status word
    always_comb begin
        logic es;
        es = 1'b0;
        nxt_sw = cur_sw;
        nxt_sw[NFLAG-1:0] = flag_nxt;
        if (clr) begin
            nxt_sw[B_SF]   = 1'b0;
            nxt_sw[B_ES]   = 1'b0;
            nxt_sw[B_BUSY] = 1'b0;
        end else if (ifault) begin
            nxt_sw[B_ES]   = 1'b1;
            nxt_sw[B_BUSY] = 1'b1;
        end else if (req.valid) begin
            if (req.stk)
                nxt_sw[B_SF] = 1'b1;
            if (req.stk || req.flags[B_PE])
                nxt_sw[B_C1] = req.c1q;
            es = any_open(flag_nxt, mask);
            nxt_sw[B_ES]   = es;
            nxt_sw[B_BUSY] = es;
        end
        if (top_ld)
            nxt_sw[B_TOP_HI:B_TOP_LO] = top_val;
    end
endmodule

// File: rtl/fpu_exc_signal.sv
// Decides whether the current event must be signalled to the core.
// Assumes the same clear > internal fault > request priority as the update logic.
module fpu_exc_signal
    import fpu_exc_pkg::*;
(
    input  exc_req_t req,
    input  logic     ifault,
    input  logic     clr,
    input  flag_t    mask,
    output logic     raise
);
    // Unmasked if any requested flag is open, or on an internal fault
    always_comb begin
        raise = 1'b0;
        if (!clr)
            raise = ifault || (req.valid && any_open(req.flags, mask));
    end
endmodule

// File: rtl/fpu_exc_status.sv
// Top of the exception status unit.
// Registers the status word and the unmasked-exception flag.
// Assumes single-cycle request strobes and a synchronous active-low reset.
module fpu_exc_status
    import fpu_exc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [5:0]       req_flags,
    input  logic             req_stack_fault,
    input  logic             req_c1,
    input  logic             int_fault,
    input  logic [15:0]      ctrl_word,
    input  logic             clear,
    input  logic             top_load,
    input  logic [2:0]       top_value,
    output logic [15:0]      status_word,
    output logic             unmasked_exc
);
    exc_req_t        req;
    flag_t           mask;
    logic [SW_W-1:0] sw_q, sw_d;
    logic            unm_q, unm_d;
    logic [9:0]      ctrl_unused;

    assign req         = '{valid: req_valid, flags: req_flags, stk: req_stack_fault, c1q: req_c1};
    assign mask        = ctrl_word[NFLAG-1:0];
    assign ctrl_unused = ctrl_word[15:6];

    fpu_exc_update u_update (
        .cur_sw (sw_q),
        .req    (req),
        .ifault (int_fault),
        .clr    (clear),
        .mask   (mask),
        .top_ld (top_load),
        .top_val(top_value),
        .nxt_sw (sw_d)
    );

    fpu_exc_signal u_signal (
        .req   (req),
        .ifault(int_fault),
        .clr   (clear),
        .mask  (mask),
        .raise (unm_d)
    );

    // State register for the status word and the trap indication
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_q  <= '0;
            unm_q <= 1'b0;
        end else begin
            sw_q  <= sw_d;
            unm_q <= unm_d;
        end
    end

    assign status_word  = sw_q;
    assign unmasked_exc = unm_q;

    // R3
    es_busy_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_q[B_ES] == sw_q[B_BUSY]);

    // R2
    flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> ((sw_q[NFLAG-1:0] & $past(sw_q[NFLAG-1:0])) == $past(sw_q[NFLAG-1:0])));

    // R8
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (sw_q[7:0] == 8'h00 && !sw_q[B_BUSY] && !unm_q));

    // R4
    int_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_fault && !clear) |=> (sw_q[NFLAG-1:0] == '1 && sw_q[B_ES] && unm_q));

    // R7
    raise_needs_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unm_q |-> sw_q[B_ES]);

    // R9
    top_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        top_load |=> (sw_q[B_TOP_HI:B_TOP_LO] == $past(top_value)));

    // R5
    c1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !int_fault && !clear && (req_stack_fault || req_flags[B_PE]))
        |=> $stable(sw_q[B_C1]));
endmodule

// File: tb/fpu_exc_status_tb.sv
`timescale 1ns/1ps
module fpu_exc_status_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [5:0]  req_flags = '0;
    logic        req_stack_fault = 1'b0;
    logic        req_c1 = 1'b0;
    logic        int_fault = 1'b0;
    logic [15:0] ctrl_word = 16'h003F;
    logic        clear = 1'b0;
    logic        top_load = 1'b0;
    logic [2:0]  top_value = '0;
    logic [15:0] status_word;
    logic        unmasked_exc;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [15:0] exp_sw_q[$];
    logic        exp_un_q[$];
    string       tag_q[$];
    logic [15:0] m_sw = '0;

    always #10 clk = ~clk;

    fpu_exc_status u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_flags(req_flags),
        .req_stack_fault(req_stack_fault), .req_c1(req_c1), .int_fault(int_fault),
        .ctrl_word(ctrl_word), .clear(clear), .top_load(top_load),
        .top_value(top_value), .status_word(status_word), .unmasked_exc(unmasked_exc)
    );

    // Driver: apply one cycle of stimulus and push the expected outcome
    task automatic op(input logic rv, input logic [5:0] rf, input logic rsf,
                      input logic rc1, input logic ifl, input logic [15:0] cw,
                      input logic clr, input logic tl, input logic [2:0] tv,
                      input string tag);
        logic [15:0] n;
        logic        un, es;
        @(negedge clk);
        req_valid = rv; req_flags = rf; req_stack_fault = rsf; req_c1 = rc1;
        int_fault = ifl; ctrl_word = cw; clear = clr; top_load = tl; top_value = tv;
        n = m_sw; un = 1'b0;
        if (clr) begin
            n[7:0] = 8'h00; n[15] = 1'b0;
        end else if (ifl) begin
            n[5:0] = 6'h3F; n[7] = 1'b1; n[15] = 1'b1; un = 1'b1;
        end else if (rv) begin
            n[5:0] = n[5:0] | rf;
            if (rsf) n[6] = 1'b1;
            if (rsf || rf[5]) n[9] = rc1;
            es = |(n[5:0] & ~cw[5:0]);
            n[7] = es; n[15] = es;
            un = |(rf & ~cw[5:0]);
        end
        if (tl) n[13:11] = tv;
        m_sw = n;
        @(posedge clk);
        #1;
        exp_sw_q.push_back(n); exp_un_q.push_back(un); tag_q.push_back(tag);
        req_valid = 1'b0; int_fault = 1'b0; clear = 1'b0; top_load = 1'b0;
    endtask

    // Monitor: compare outputs against queued expectations away from the edge
    always @(negedge clk) begin
        if (exp_sw_q.size() > 0) begin
            logic [15:0] esw;
            logic        eun;
            string       t;
            esw = exp_sw_q.pop_front(); eun = exp_un_q.pop_front(); t = tag_q.pop_front();
            checks++;
            if (status_word !== esw || unmasked_exc !== eun) begin
                errors++;
                $display("FAIL %s: status=%h unmasked=%b expected status=%h unmasked=%b",
                         t, status_word, unmasked_exc, esw, eun);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        checks++;
        if (status_word !== 16'h0000 || unmasked_exc !== 1'b0) begin
            errors++;
            $display("FAIL R1: status=%h unmasked=%b expected status=0000 unmasked=0",
                     status_word, unmasked_exc);
        end
        rst_n = 1'b1;
        // R7: masked denormal sets only bit 1
        op(1, 6'h02, 0, 0, 0, 16'h003F, 0, 0, 3'd0, "R7 masked denormal");
        // R3/R7: unmasked zero-divide
        op(1, 6'h04, 0, 0, 0, 16'h003B, 0, 0, 3'd0, "R3 unmasked zero-divide");
        // R2: sticky, masked overflow adds bit 3
        op(1, 6'h08, 0, 0, 0, 16'h003F, 0, 0, 3'd0, "R2 sticky overflow");
        // R9: load stack top
        op(0, 6'h00, 0, 0, 0, 16'h003F, 0, 1, 3'd5, "R9 top load");
        // R5: precision rounded up
        op(1, 6'h20, 0, 1, 0, 16'h003F, 0, 0, 3'd0, "R5 precision up");
        // R5: non-precision request keeps C1
        op(1, 6'h10, 0, 0, 0, 16'h003F, 0, 0, 3'd0, "R5 C1 kept");
        // R8: clear keeps C1 and top
        op(0, 6'h00, 0, 0, 0, 16'h003F, 1, 0, 3'd0, "R8 clear");
        // R5: precision rounded down
        op(1, 6'h20, 0, 0, 0, 16'h003F, 0, 0, 3'd0, "R5 precision down");
        // R6/R10: stack overflow with upper control bits set
        op(1, 6'h01, 1, 1, 0, 16'hFF3F, 0, 0, 3'd0, "R6 stack overflow");
        // R6: stack underflow clears C1
        op(1, 6'h01, 1, 0, 0, 16'h003F, 0, 0, 3'd0, "R6 stack underflow");
        // idle cycle: no change, no trap
        op(0, 6'h00, 0, 0, 0, 16'h0000, 0, 0, 3'd0, "R7 idle");
        op(0, 6'h00, 0, 0, 0, 16'h003F, 1, 0, 3'd0, "R8 clear again");
        // R3: summary drops when a previously open flag becomes masked
        op(1, 6'h01, 0, 0, 0, 16'h003E, 0, 0, 3'd0, "R3 invalid open");
        op(1, 6'h08, 0, 0, 0, 16'h003F, 0, 0, 3'd0, "R3 summary recomputed");
        // R10: upper control bits do not unmask
        op(1, 6'h02, 0, 0, 0, 16'hFFFF, 0, 0, 3'd0, "R10 upper control bits");
        // R4: internal fault with all masks set and a competing request
        op(1, 6'h20, 1, 1, 1, 16'h003F, 0, 0, 3'd0, "R4 internal fault priority");
        // R8: clear beats internal fault and request
        op(1, 6'h04, 0, 0, 1, 16'h0000, 1, 0, 3'd0, "R8 clear priority");
        // R9: top load during clear
        op(0, 6'h00, 0, 0, 0, 16'h003F, 1, 1, 3'd2, "R9 top load with clear");
        // R7: unmasked underflow request
        op(1, 6'h10, 0, 0, 0, 16'h002F, 0, 0, 3'd0, "R7 unmasked underflow");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
    end

    // Watchdog and final report
    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule